// File: doc/BRIEF.md
# Timer-Driven Square-Wave Divider

This block produces a square wave whose frequency is set by software through a small write/read register port. It has two independent 8-bit up-counting timers. Each timer has its own prescaler and preload value. A timer counts from its preload value up to all ones and then emits a one-cycle overflow. It then reloads itself and goes on counting without any software help.

A source-select field chooses which timer's overflow flips an output flip-flop. The output period is therefore two overflow intervals. One interval lasts (256 − preload) × 2^(prescale+1) system clocks.

The wave leaves the block on a general-purpose pin that it shares with an ordinary port bit. While the divider is disabled, the pin behaves as plain GPIO, driven by the port data and direction bits. While the divider is enabled, it reaches the pin only when the direction bit selects output and the port data bit is 1. A data bit of 0 holds the pin low. The live pin level can always be read back through the register port.

Top module: `freq_div_gen`

## Requirements
- R1: While `rst` is high, every register, both timers and the output flip-flop clear. In the cycle after reset, `pad_out`, `pad_oe` and `rd_data` are 0.
- R2: A running timer advances by one count per prescaler tick. From preload P it reaches 8'hFF, and on the next tick it raises a single-cycle overflow. With the timer selected and the pin passing the wave, each half period of `pad_out` lasts (256 − P) × 2^(f+1) clocks.
- R3: At each overflow the timer reloads the preload value currently held in its register, with no software action. Successive half periods are therefore equal, and a preload written while the timer runs takes effect from the next reload.
- R4: The 3-bit prescale field f, in bits [2:0] of a timer's control register, divides the system clock by 2^(f+1), from 2 up to 256.
- R5: The select field, in bit 3 of the pin register, picks timer 0 (value 0) or timer 1 (value 1) as the toggle source.
- R6: Each overflow of the selected timer inverts the output flip-flop. The flip-flop holds 0 while the divider enable bit is 0, so after enabling, the wave starts low.
- R7: With the divider enable bit (bit 0 of the pin register) at 0, `pad_out` follows the port data bit (bit 2) and `pad_oe` follows the direction bit (bit 1, 1 = output), each one cycle after the register changes.
- R8: With the divider enabled and the direction bit at 0, `pad_oe` is 0 and `pad_out` is 0, so the wave never reaches the pin.
- R9: With the divider enabled, the direction bit at 1 and the port data bit at 0, `pad_out` stays 0 regardless of timer activity.
- R10: While a timer is stopped (run bit 7 of its control register at 0), a preload write also loads its counter. After the run bit is set with f = 0 and preload 8'hFC, `pad_out` rises 11 clock edges after the edge that latched the run bit, counting that edge as the first.
- R11: `rd_data` returns, one cycle after `rd_addr` is presented: the preload registers (addresses 0 and 2); the control registers {run, 4'b0, f} (addresses 1 and 3); the pin register {sel, data, dir, en} in bits [3:0] (address 4); and `pad_in` in bit 0 (address 5).
- R12: Overflows of the unselected timer leave `pad_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| pad_in | input | 1 | Level sensed on the shared pin |
| pad_out | output | 1 | Level driven onto the shared pin |
| pad_oe | output | 1 | Pin output enable (1 = drive) |

## Verification
A corrupted counter, prescaler phase or reload value shows at the pin as a wrong half-period length. The error is visible at the first edge of `pad_out` that follows, at most one interval (up to 65,536 clocks) later. A stuck or mis-cleared toggle flip-flop shows as a wave that starts high after enabling, or that inverts when the unselected timer overflows. This surfaces two clocks after the faulty overflow, because the flip-flop and the pad register each add one cycle. A wrong pin-mode decision is visible on `pad_out`/`pad_oe` in the cycle after the pin register is written. The bench compares every cycle against an independent behavioural model, which catches each of these cases at the cycle where it first appears.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // bit positions inside the pin-configuration register
  localparam int EN_B    = 0;
  localparam int DIR_B   = 1;
  localparam int DAT_B   = 2;
  localparam int SEL_LSB = 3;

  // what the shared pin is doing this cycle
  typedef enum logic [1:0] {
    PIN_GPIO = 2'd0,  // divider off, plain port bit
    PIN_HIZ  = 2'd1,  // divider on, pin is an input
    PIN_MUTE = 2'd2,  // divider on, gated off by data bit
    PIN_WAVE = 2'd3   // divider on, wave reaches the pin
  } pin_mode_t;

endpackage

// File: rtl/fdiv_regs.sv
module fdiv_regs
  import fdiv_pkg::*;
#(
  parameter int NTMR   = 2,
  parameter int CNT_W  = 8,
  parameter int PSC_W  = 3,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CNT_W-1:0]             wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic                         pad_in,
  output logic [NTMR-1:0][CNT_W-1:0]   pre,
  output logic [NTMR-1:0][PSC_W-1:0]   psc,
  output logic [NTMR-1:0]              run,
  output logic [NTMR-1:0]              load,
  output logic                         en,
  output logic                         dir,
  output logic                         dat,
  output logic [SEL_W-1:0]             sel,
  output logic [CNT_W-1:0]             rd_data
);

  localparam int RUN_B  = CNT_W - 1;
  localparam int MISC_A = 2 * NTMR;
  localparam int PAD_A  = 2 * NTMR + 1;

  logic [CNT_W-1:0] rd_next;

  // direct counter load strobes (used by a stopped timer)
  generate
    for (genvar g = 0; g < NTMR; g++) begin : g_load
      assign load[g] = wr_en && (wr_addr == ADDR_W'(2 * g));
    end
  endgenerate

  // per-timer preload and control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      psc <= '0;
      run <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NTMR; i++) begin
        if (wr_addr == ADDR_W'(2 * i)) begin
          pre[i] <= wr_data;
        end
        if (wr_addr == ADDR_W'(2 * i + 1)) begin
          psc[i] <= wr_data[PSC_W-1:0];
          run[i] <= wr_data[RUN_B];
        end
      end
    end
  end

  // pin configuration register
  always_ff @(posedge clk) begin
    if (rst) begin
      en  <= 1'b0;
      dir <= 1'b0;
      dat <= 1'b0;
      sel <= '0;
    end else if (wr_en && (wr_addr == ADDR_W'(MISC_A))) begin
      en  <= wr_data[EN_B];
      dir <= wr_data[DIR_B];
      dat <= wr_data[DAT_B];
      sel <= wr_data[SEL_LSB +: SEL_W];
    end
  end

  // read mux
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NTMR; i++) begin
      if (rd_addr == ADDR_W'(2 * i)) begin
        rd_next = pre[i];
      end
      if (rd_addr == ADDR_W'(2 * i + 1)) begin
        rd_next[PSC_W-1:0] = psc[i];
        rd_next[RUN_B]     = run[i];
      end
    end
    if (rd_addr == ADDR_W'(MISC_A)) begin
      rd_next[EN_B]               = en;
      rd_next[DIR_B]              = dir;
      rd_next[DAT_B]              = dat;
      rd_next[SEL_LSB +: SEL_W]   = sel;
    end
    if (rd_addr == ADDR_W'(PAD_A)) begin
      rd_next[0] = pad_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/fdiv_timer.sv
module fdiv_timer #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] psc,
  input  logic [CNT_W-1:0] preload,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             ovf
);

  // prescaler is a free-running binary counter; a tick is taken when
  // its low (psc+1) bits are all ones, giving a ratio of 2^(psc+1)
  localparam int PCNT_W = 1 << PSC_W;

  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] mask;
  logic [CNT_W-1:0]  cnt;
  logic              tick;
  logic              full;

  assign mask = (PCNT_W'(2) << psc) - PCNT_W'(1);
  assign tick = run && ((pcnt & mask) == mask);
  assign full = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      ovf <= tick && full;
      if (run) begin
        pcnt <= pcnt + PCNT_W'(1);
      end else begin
        pcnt <= '0;
      end
      if (!run && load) begin
        cnt <= load_val;
      end else if (tick) begin
        cnt <= full ? preload : cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/fdiv_pin.sv
module fdiv_pin
  import fdiv_pkg::*;
#(
  parameter int NTMR  = 2,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTMR-1:0]  ovf,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  input  logic             dir,
  input  logic             dat,
  output logic             tog,
  output logic             pad_out,
  output logic             pad_oe
);

  logic      src_ovf;
  pin_mode_t mode;

  always_comb begin
    src_ovf = 1'b0;
    for (int i = 0; i < NTMR; i++) begin
      if (sel == SEL_W'(i)) begin
        src_ovf = ovf[i];
      end
    end
  end

  always_comb begin
    if (!en) begin
      mode = PIN_GPIO;
    end else if (!dir) begin
      mode = PIN_HIZ;
    end else if (!dat) begin
      mode = PIN_MUTE;
    end else begin
      mode = PIN_WAVE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog     <= 1'b0;
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      tog    <= en ? (tog ^ src_ovf) : 1'b0;
      pad_oe <= dir;
      unique case (mode)
        PIN_GPIO: pad_out <= dat;
        PIN_WAVE: pad_out <= tog;
        default:  pad_out <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/freq_div_gen.sv
module freq_div_gen #(
  parameter int NTMR   = 2,
  parameter int CNT_W  = 8,
  parameter int PSC_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              pad_in,
  output logic              pad_out,
  output logic              pad_oe
);

  localparam int SEL_W = (NTMR > 1) ? $clog2(NTMR) : 1;

  logic [NTMR-1:0][CNT_W-1:0] pre_v;
  logic [NTMR-1:0][PSC_W-1:0] psc_v;
  logic [NTMR-1:0]            run_v;
  logic [NTMR-1:0]            load_v;
  logic [NTMR-1:0]            ovf_v;
  logic                       cfg_en;
  logic                       cfg_dir;
  logic                       cfg_dat;
  logic [SEL_W-1:0]           src_sel;
  logic                       tog_q;

  fdiv_regs #(
    .NTMR(NTMR), .CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .pad_in(pad_in), .pre(pre_v), .psc(psc_v), .run(run_v),
    .load(load_v), .en(cfg_en), .dir(cfg_dir), .dat(cfg_dat), .sel(src_sel),
    .rd_data(rd_data)
  );

  generate
    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
      fdiv_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tmr (
        .clk(clk), .rst(rst), .run(run_v[g]), .psc(psc_v[g]),
        .preload(pre_v[g]), .load(load_v[g]), .load_val(wr_data),
        .ovf(ovf_v[g])
      );
    end
  endgenerate

  fdiv_pin #(.NTMR(NTMR), .SEL_W(SEL_W)) u_pin (
    .clk(clk), .rst(rst), .ovf(ovf_v), .sel(src_sel), .en(cfg_en),
    .dir(cfg_dir), .dat(cfg_dat), .tog(tog_q), .pad_out(pad_out),
    .pad_oe(pad_oe)
  );

endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk #(
  parameter int NTMR  = 2,
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             pad_out,
  input logic             pad_oe,
  input logic             en,
  input logic             dir,
  input logic             dat,
  input logic             tog,
  input logic [NTMR-1:0]  ovf,
  input logic [SEL_W-1:0] sel
);

  logic pick;
  always_comb begin
    pick = 1'b0;
    if (int'(sel) < NTMR) begin
      pick = ovf[sel];
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!pad_out && !pad_oe && !tog));

  // R2
  ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|ovf) |=> ((ovf & $past(ovf)) == '0));

  // R6
  tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !pick) |=> (tog == $past(tog)));

  // R6
  tog_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pick) |=> (tog != $past(tog)));

  // R7
  gpio_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ((pad_out == $past(dat)) && (pad_oe == $past(dir))));

  // R8
  input_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !dir) |=> (!pad_out && !pad_oe));

  // R9
  data_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (en && dir && !dat) |=> !pad_out);

endmodule

bind freq_div_gen fdiv_chk #(.NTMR(NTMR), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .pad_out(pad_out), .pad_oe(pad_oe), .en(cfg_en),
  .dir(cfg_dir), .dat(cfg_dat), .tog(tog_q), .ovf(ovf_v), .sel(src_sel)
);

// File: tb/freq_div_gen_test.sv
`timescale 1ns/100ps
module freq_div_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       pad_in = 1'b0;
  logic       pad_out;
  logic       pad_oe;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #2.5 clk = ~clk;

  freq_div_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe)
  );

  // ---------------- behavioural reference model ----------------
  int m_pre[2], m_psc[2], m_run[2], m_cnt[2], m_pc[2], m_ovf[2];
  int n_cnt[2], n_pc[2], n_ovf[2];
  int m_en, m_dir, m_dat, m_sel, m_tog, m_pout, m_poe, m_rd;
  int n_tog, n_pout, n_poe, n_rd, ratio;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_pre[i] = 0; m_psc[i] = 0; m_run[i] = 0;
        m_cnt[i] = 0; m_pc[i] = 0; m_ovf[i] = 0;
      end
      m_en = 0; m_dir = 0; m_dat = 0; m_sel = 0;
      m_tog = 0; m_pout = 0; m_poe = 0; m_rd = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        n_ovf[i] = 0;
        n_cnt[i] = m_cnt[i];
        if (m_run[i] != 0) begin
          ratio = 2 ** (m_psc[i] + 1);
          n_pc[i] = (m_pc[i] + 1) % 256;
          if ((m_pc[i] % ratio) == ratio - 1) begin
            if (m_cnt[i] == 255) begin
              n_ovf[i] = 1;
              n_cnt[i] = m_pre[i];
            end else begin
              n_cnt[i] = m_cnt[i] + 1;
            end
          end
        end else begin
          n_pc[i] = 0;
          if (wr_en && wr_addr == 3'(2 * i)) n_cnt[i] = wr_data;
        end
      end
      n_tog = (m_en == 0) ? 0 : ((m_ovf[m_sel] != 0) ? 1 - m_tog : m_tog);
      n_pout = (m_en == 0) ? m_dat : ((m_dir != 0 && m_dat != 0 && m_tog != 0) ? 1 : 0);
      n_poe = m_dir;
      case (rd_addr)
        3'd0: n_rd = m_pre[0];
        3'd1: n_rd = m_run[0] * 128 + m_psc[0];
        3'd2: n_rd = m_pre[1];
        3'd3: n_rd = m_run[1] * 128 + m_psc[1];
        3'd4: n_rd = m_en + 2 * m_dir + 4 * m_dat + 8 * m_sel;
        3'd5: n_rd = pad_in;
        default: n_rd = 0;
      endcase
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_pre[0] = wr_data;
          3'd1: begin m_psc[0] = wr_data % 8; m_run[0] = wr_data / 128; end
          3'd2: m_pre[1] = wr_data;
          3'd3: begin m_psc[1] = wr_data % 8; m_run[1] = wr_data / 128; end
          3'd4: begin
            m_en = wr_data[0]; m_dir = wr_data[1];
            m_dat = wr_data[2]; m_sel = wr_data[3];
          end
          default: ;
        endcase
      end
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = n_cnt[i]; m_pc[i] = n_pc[i]; m_ovf[i] = n_ovf[i];
      end
      m_tog = n_tog; m_pout = n_pout; m_poe = n_poe; m_rd = n_rd;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model, tagged by pin situation
  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      if (m_en == 0)
        chk(pad_out == m_pout && pad_oe == m_poe, "R7 gpio pin", {pad_oe, pad_out}, m_poe * 2 + m_pout);
      else if (m_dir == 0)
        chk(pad_out == m_pout && pad_oe == m_poe, "R8 input pin", {pad_oe, pad_out}, m_poe * 2 + m_pout);
      else if (m_dat == 0)
        chk(pad_out == m_pout && pad_oe == m_poe, "R9 gated pin", {pad_oe, pad_out}, m_poe * 2 + m_pout);
      else
        chk(pad_out == m_pout && pad_oe == m_poe, "R6 wave pin", {pad_oe, pad_out}, m_poe * 2 + m_pout);
      chk(rd_data == 8'(m_rd), "R11 readback", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic half(output int n);
    logic v;
    int guard;
    v = pad_out; guard = 0;
    while (pad_out == v && guard < 5000) begin @(negedge clk); guard++; end
    v = pad_out; n = 0;
    while (pad_out == v && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic hold_check(input int cycles, input logic exp_out, input logic exp_oe,
                            input string req);
    int miss;
    miss = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (pad_out !== exp_out || pad_oe !== exp_oe) miss++;
    end
    chk(miss == 0, req, miss, 0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    chk(pad_out == 1'b0 && pad_oe == 1'b0 && rd_data == 8'h00, "R1 reset state",
        {rd_data, pad_oe, pad_out}, 0);
    cmp_on = 1;

    // enable, pin output, data 1, source timer 0
    wr(3'd4, 8'h07);
    // R10: stopped preload write loads the counter
    wr(3'd0, 8'hFC);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h80;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk); wr_en = 1'b0;
    end while (!pad_out && n < 100);
    chk(n == 11, "R10 first rise after start", n, 11);

    // R2 / R3: interval (256-0xFC)*2 = 8, repeating
    half(n); chk(n == 8, "R2 half period f=0", n, 8);
    half(n); chk(n == 8, "R3 reload repeat", n, 8);

    // R4: f=2, preload F0 -> 16*8 = 128
    wr(3'd1, 8'h02);
    wr(3'd0, 8'hF0);
    wr(3'd1, 8'h82);
    half(n); chk(n == 128, "R4 prescale 8", n, 128);
    half(n); chk(n == 128, "R4 prescale 8 repeat", n, 128);

    // R3: preload change while running -> 8*8 = 64 from next reload
    wr(3'd0, 8'hF8);
    half(n); chk(n == 64, "R3 running preload", n, 64);

    // R5: timer 1, preload FE, f=1 -> 2*4 = 8
    wr(3'd2, 8'hFE);
    wr(3'd3, 8'h81);
    wr(3'd4, 8'h0F);
    half(n); chk(n == 8, "R5 timer1 source", n, 8);
    half(n); chk(n == 8, "R5 timer1 repeat", n, 8);

    // R12: timer 1 stopped, timer 0 keeps overflowing unselected
    wr(3'd3, 8'h01);
    @(negedge clk);
    hold_check(300, pad_out, 1'b1, "R12 unselected overflow");

    // R9: enabled, output, data 0 -> low
    wr(3'd4, 8'h03);
    @(negedge clk);
    hold_check(200, 1'b0, 1'b1, "R9 data gate low");

    // R8: enabled, input direction -> not driven
    wr(3'd4, 8'h05);
    @(negedge clk);
    hold_check(150, 1'b0, 1'b0, "R8 input suppresses wave");

    // R7: divider off, pin follows port bits
    wr(3'd4, 8'h06);
    @(negedge clk);
    hold_check(20, 1'b1, 1'b1, "R7 gpio high");
    wr(3'd4, 8'h02);
    @(negedge clk);
    hold_check(20, 1'b0, 1'b1, "R7 gpio low");

    // R6: re-enable starts low, then half period 64
    wr(3'd4, 8'h07);
    chk(pad_out == 1'b0, "R6 starts low", pad_out, 0);
    half(n); chk(n == 64, "R6 toggle interval", n, 64);

    // R11: readback
    @(negedge clk); rd_addr = 3'd4;
    @(negedge clk); chk(rd_data == 8'h07, "R11 pin register", rd_data, 8'h07);
    pad_in = 1'b1; rd_addr = 3'd5;
    @(negedge clk); chk(rd_data == 8'h01, "R11 pad high", rd_data, 1);
    pad_in = 1'b0;
    @(negedge clk); chk(rd_data == 8'h00, "R11 pad low", rd_data, 0);
    rd_addr = 3'd0;
    @(negedge clk); chk(rd_data == 8'hF8, "R11 preload", rd_data, 8'hF8);
    rd_addr = 3'd1;
    @(negedge clk); chk(rd_data == 8'h82, "R11 control", rd_data, 8'h82);

    repeat (4) @(negedge clk);
    done = 1;
    summary();
  end

endmodule